// File: doc/BRIEF.md
# Operand Bypass Selector with Load-Use Interlock

This block picks the source of both ALU operands in the execute stage of a five-stage pipeline. An operand can come from three places: the register-file value that entered the ID/EX register, the ALU result waiting in the EX/M register, or the value about to be written back from the M/WB register. An ALU result exists at the end of EX, long before it reaches the register file in WB. Steering it back to the next instruction's EX input avoids most stalls caused by register dependences.

One dependence cannot be bypassed. A load has its data only at the end of the memory stage, so an instruction that reads the loaded register right behind it would need the value one cycle too soon. The block detects this case while the consumer is still in decode. It asks the pipeline to hold the PC and the IF/ID register for one cycle and to put a bubble into EX. On the following cycle the load has reached M/WB and normal bypassing delivers its data. The block is purely combinational: it compares register numbers and decodes write enables, and the surrounding pipeline registers stay outside it.

Top module: `fwd_hazard_unit`

## Requirements
- R1: An operand whose source register matches no enabled, non-zero destination in EX/M or M/WB gets select 2'b00 (register-file value).
- R2: An operand whose source register equals the EX/M destination, with the EX/M write enable high and the destination not zero, gets select 2'b10.
- R3: An operand that matches an enabled, non-zero M/WB destination, and does not match EX/M under R2, gets select 2'b01.
- R4: When both EX/M and M/WB qualify for the same operand, the select is 2'b10: the younger result wins.
- R5: Register 0 is never forwarded: a source register of 0 always gets select 2'b00.
- R6: A producer whose write enable is low is ignored for forwarding, even when its destination number matches.
- R7: The two operands are decided independently. Operand A uses `ex_src_a` and drives `sel_a`, and operand B uses `ex_src_b` and drives `sel_b`. The select value 2'b11 never appears.
- R8: If the instruction in EX is a load (load flag high, write enable high, destination not zero) and the decoding instruction reads that destination through an operand whose use flag is high, both `hold_front` and `flush_ex` are 1.
- R9: No stall is raised for a load whose destination is matched only by an operand whose use flag is low, or whose destination is register 0. `hold_front` and `flush_ex` are always equal.
- R10: A non-load producer in EX never causes a stall, even when its destination matches a source the decoding instruction reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | AW | Operand A source register of the instruction in decode |
| id_src_b | input | AW | Operand B source register of the instruction in decode |
| id_use_a | input | 1 | Decoding instruction actually reads operand A |
| id_use_b | input | 1 | Decoding instruction actually reads operand B |
| ex_src_a | input | AW | Operand A source register held in ID/EX |
| ex_src_b | input | AW | Operand B source register held in ID/EX |
| ex_dst | input | AW | Destination register of the instruction in EX |
| ex_wen | input | 1 | Register write enable of the instruction in EX |
| ex_load | input | 1 | Instruction in EX is a load |
| exm_dst | input | AW | Destination register held in EX/M |
| exm_wen | input | 1 | Register write enable held in EX/M |
| mwb_dst | input | AW | Destination register held in M/WB |
| mwb_wen | input | 1 | Register write enable held in M/WB |
| sel_a | output | 2 | Operand A source: 00 register file, 10 EX/M, 01 M/WB |
| sel_b | output | 2 | Operand B source: 00 register file, 10 EX/M, 01 M/WB |
| hold_front | output | 1 | Keep PC and IF/ID unchanged this cycle |
| flush_ex | output | 1 | Load a bubble (all control cleared) into ID/EX |

## Verification
The assertions assume that the pipeline presents a stable, settled set of register numbers and enables whenever they are evaluated. They also assume that the load flag in EX is meaningful only together with that stage's write enable, so the load-use check treats a load with the enable low as harmless. The stimulus changes all inputs together, once per cycle, away from the clock edge, and never leaves them half-updated. It draws register numbers from a small range that includes 0, so matches, double matches and register-0 cases occur often. Enables, use flags and the load flag are drawn freely, which also covers every combination the assumptions allow.

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic          id_use_a,
  input  logic          id_use_b,
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] exm_dst,
  input  logic          exm_wen,
  input  logic [AW-1:0] mwb_dst,
  input  logic          mwb_wen,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          hold_front,
  output logic          flush_ex
);

  localparam logic [1:0] SRC_RF  = 2'b00;
  localparam logic [1:0] SRC_EXM = 2'b10;
  localparam logic [1:0] SRC_MWB = 2'b01;
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic exm_live, mwb_live, load_live;
  logic exm_hit_a, exm_hit_b, mwb_hit_a, mwb_hit_b;
  logic lu_a, lu_b, lu_stall;

  assign exm_live  = exm_wen && (exm_dst != ZERO_REG);
  assign mwb_live  = mwb_wen && (mwb_dst != ZERO_REG);
  assign load_live = ex_load && ex_wen && (ex_dst != ZERO_REG);

  assign exm_hit_a = exm_live && (exm_dst == ex_src_a);
  assign exm_hit_b = exm_live && (exm_dst == ex_src_b);
  assign mwb_hit_a = mwb_live && (mwb_dst == ex_src_a);
  assign mwb_hit_b = mwb_live && (mwb_dst == ex_src_b);

  assign sel_a = exm_hit_a ? SRC_EXM : (mwb_hit_a ? SRC_MWB : SRC_RF);
  assign sel_b = exm_hit_b ? SRC_EXM : (mwb_hit_b ? SRC_MWB : SRC_RF);

  assign lu_a     = id_use_a && (id_src_a == ex_dst);
  assign lu_b     = id_use_b && (id_src_b == ex_dst);
  assign lu_stall = load_live && (lu_a || lu_b);

  assign hold_front = lu_stall;
  assign flush_ex   = lu_stall;

endmodule

module fwd_hazard_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_src_a,
  input logic [AW-1:0] id_src_b,
  input logic          id_use_a,
  input logic          id_use_b,
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [AW-1:0] ex_dst,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] exm_dst,
  input logic          exm_wen,
  input logic [AW-1:0] mwb_dst,
  input logic          mwb_wen,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic          hold_front,
  input logic          flush_ex
);

  always_comb begin
    // R7
    sel_legal_chk: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select code 11 seen");
    // R2
    exm_src_chk: assert (sel_a != 2'b10 || (exm_wen && exm_dst == ex_src_a && exm_dst != '0))
      else $error("operand A took EX/M without a qualifying producer");
    // R4
    mwb_prio_chk: assert (sel_b != 2'b01 || !(exm_wen && exm_dst == ex_src_b && exm_dst != '0))
      else $error("operand B took M/WB while EX/M qualified");
    // R5
    zero_reg_chk: assert ((ex_src_a != '0 || sel_a == 2'b00) && (ex_src_b != '0 || sel_b == 2'b00))
      else $error("register 0 forwarded");
    // R6
    wen_low_chk: assert ((exm_wen || mwb_wen) || (sel_a == 2'b00 && sel_b == 2'b00))
      else $error("forwarding with both producer enables low");
    // R9
    pair_chk: assert (hold_front == flush_ex)
      else $error("hold and flush disagree");
    // R10
    nonload_chk: assert (ex_load || !hold_front)
      else $error("stall raised behind a non-load");
    // R8
    stall_cause_chk: assert (!hold_front || (ex_wen && ex_dst != '0 &&
                             ((id_use_a && id_src_a == ex_dst) || (id_use_b && id_src_b == ex_dst))))
      else $error("stall without a load-use dependence");
  end

endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.AW(AW)) u_chk (
  .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
  .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst), .ex_wen(ex_wen),
  .ex_load(ex_load), .exm_dst(exm_dst), .exm_wen(exm_wen), .mwb_dst(mwb_dst),
  .mwb_wen(mwb_wen), .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front),
  .flush_ex(flush_ex)
);

// File: tb/sim_fwd_hazard_unit.sv
module sim_fwd_hazard_unit;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, exm_dst, mwb_dst;
  logic id_use_a, id_use_b, ex_wen, ex_load, exm_wen, mwb_wen;
  logic [1:0] sel_a, sel_b;
  logic hold_front, flush_ex;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  fwd_hazard_unit #(.AW(AW)) u0 (
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_dst(ex_dst), .ex_wen(ex_wen),
    .ex_load(ex_load), .exm_dst(exm_dst), .exm_wen(exm_wen), .mwb_dst(mwb_dst),
    .mwb_wen(mwb_wen), .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front),
    .flush_ex(flush_ex)
  );

  function automatic logic [1:0] want_sel(logic [AW-1:0] src);
    if (src != 0 && exm_wen && exm_dst == src) return 2'b10;
    if (src != 0 && mwb_wen && mwb_dst == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string sel_tag(logic [AW-1:0] src);
    logic m1, m2;
    m1 = exm_dst == src;
    m2 = mwb_dst == src;
    if (src == 0 && (m1 || m2)) return "R5";
    if (m1 && exm_wen && m2 && mwb_wen) return "R4";
    if (m1 && exm_wen) return "R2";
    if (m2 && mwb_wen) return "R3";
    if (m1 || m2) return "R6";
    return "R1";
  endfunction

  function automatic logic want_stall();
    return ex_load && ex_wen && ex_dst != 0 &&
           ((id_use_a && id_src_a == ex_dst) || (id_use_b && id_src_b == ex_dst));
  endfunction

  task automatic check2(string tag, logic [1:0] got, logic [1:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, got, exp);
    end
  endtask

  task automatic check_all();
    logic st;
    string tg;
    st = want_stall();
    check2(sel_tag(ex_src_a), sel_a, want_sel(ex_src_a), "sel_a");
    check2("R7", sel_b, want_sel(ex_src_b), "sel_b");
    tg = st ? "R8" : (ex_load ? "R9" : "R10");
    check2(tg, {1'b0, hold_front}, {1'b0, st}, "hold_front");
    check2("R9", {1'b0, flush_ex}, {1'b0, st}, "flush_ex");
  endtask

  task automatic drive(logic [AW-1:0] isa, logic [AW-1:0] isb, logic ua, logic ub,
                       logic [AW-1:0] esa, logic [AW-1:0] esb, logic [AW-1:0] ed,
                       logic ew, logic el, logic [AW-1:0] md, logic mw,
                       logic [AW-1:0] wd, logic ww);
    @(negedge clk);
    id_src_a = isa; id_src_b = isb; id_use_a = ua; id_use_b = ub;
    ex_src_a = esa; ex_src_b = esb; ex_dst = ed; ex_wen = ew; ex_load = el;
    exm_dst = md; exm_wen = mw; mwb_dst = wd; mwb_wen = ww;
    #2;
    check_all();
  endtask

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R1 reset-like idle state
    check2("R1", sel_a, 2'b00, "idle sel_a");
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R2 EX/M producer feeds A
    drive(0, 0, 0, 0, 7, 3, 0, 0, 0, 7, 1, 9, 1);
    // R3 M/WB producer feeds B
    drive(0, 0, 0, 0, 4, 9, 0, 0, 0, 7, 1, 9, 1);
    // R4 both stages match
    drive(0, 0, 0, 0, 6, 6, 0, 0, 0, 6, 1, 6, 1);
    // R5 register 0
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    // R6 write enable low
    drive(0, 0, 0, 0, 5, 5, 0, 0, 0, 5, 0, 5, 0);
    // R8 load-use on B
    drive(3, 8, 1, 1, 0, 0, 8, 1, 1, 0, 0, 0, 0);
    // R9 matching operand unused
    drive(8, 2, 0, 1, 0, 0, 8, 1, 1, 0, 0, 0, 0);
    // R9 load to register 0
    drive(0, 0, 1, 1, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    // R10 ALU producer in EX
    drive(8, 8, 1, 1, 0, 0, 8, 1, 0, 0, 0, 0, 0);
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      drive($urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
            $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 2, $urandom % 2,
            $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule